// File: doc/BRIEF.md
# Capture-Compare Timer with Compare Shortcuts

This block is a register-mapped timer/counter with a parameterized number of capture/compare channels, from one to six. Software drives it through one write/read port. It configures the operating mode, the counter width and the prescaler. It fires action bits in a task word and reads back the per-channel compare flags and channel registers.

In timer mode, the counter advances on prescaled clock ticks. In either counter mode, it advances once for each count task. Each channel can capture the live count. Each channel also raises a sticky compare flag when the count steps onto its stored value. Per-channel shortcut bits can stop the run or clear the counter after a compare. A per-channel one-shot option fires a compare only once, until software writes that channel's register again.

The run control is a two-state machine:
- `ST_IDLE` moves to `ST_RUN` on the START transition, which is a start task with no stop, shutdown or pending compare-stop in the same cycle.
- `ST_RUN` moves to `ST_IDLE` on the STOP transition, which is caused by a stop task, a shutdown task or a pending compare-stop shortcut.

Top module: `cc_timer`

## Requirements
- R1: After reset the run state is ST_IDLE and the counter is 0. Every configuration register, flag and channel register reads 0, and irq is low.
- R2: Address 0x00 is a write-only task word that reads 0. Its bits are: bit0 start, bit1 stop, bit2 count, bit3 clear, bit4 shutdown, and bit 8+n capture on channel n. Several bits in one write act in the same cycle, and stop beats start.
- R3: When the mode field is 0 (timer mode) and the timer is running, the counter advances once every 2^p cycles, where p is the prescaler. The prescaler is at address 0x06, bits [3:0], and a value above 9 is stored as 9. The clock divider restarts from 0 on a clear or a shutdown.
- R4: When the mode field (address 0x04, bits [1:0]) is nonzero, the counter advances once per count task while running. A count task while stopped has no effect.
- R5: The width field (address 0x05, bits [1:0]) selects 8, 16, 24 or 32 bits for codes 0, 1, 2 and 3. The counter wraps from the top value of that width to 0.
- R6: A channel's compare flag sets on the clock edge at which an increment makes the counter equal to that channel's register. The flag reads as bit0 at address 0x08+n. A write of 0 to that address clears it, a nonzero write is ignored, and a new compare beats the clear.
- R7: The shortcut register is at address 0x01. Bit n stops the run and bit 8+n clears the counter, both acting in the cycle after channel n compares. During that cycle, a pending stop blocks any increment and a pending clear overrides one.
- R8: Writing 1s to address 0x02 enables interrupts and writing 1s to address 0x03 disables them; both addresses read the enable mask, with channel n at bit n. irq is high exactly while some enabled channel's flag is set.
- R9: A capture stores the counter value held before that cycle's update. The stored value therefore excludes any clear or increment that happens in the same cycle.
- R10: When one-shot bit n (address 0x07) is set, channel n compares once and then stays disarmed until software writes its channel register.
- R11: Shutdown stops the run and zeroes both the counter and the clock divider.
- R12: The channel registers at address 0x10+n are 32-bit read/write. A compare needs the full 32-bit value to match, so a value above the selected width never fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_addr | input | ADDR_W | Word address for read and write |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data for bus_addr |
| irq | output | 1 | Level interrupt from the enabled compare flags |

## Verification
The collisions that matter are a counter clear landing in the same cycle as a capture, and a count step landing in the same cycle as a capture. Both are provoked with single task-word writes that set the clear and capture bits, or the count and capture bits, together. A compare-clear shortcut is also allowed to meet a running prescaler tick. A behavioural reference model in the bench applies the requirement rules every clock, and the captured values and irq must match that model exactly.

// File: rtl/cc_timer_pkg.sv
package cc_timer_pkg;

    // Run-control state
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;

    // Register word addresses
    localparam int unsigned A_TASK     = 0;
    localparam int unsigned A_SHORT    = 1;
    localparam int unsigned A_IEN_SET  = 2;
    localparam int unsigned A_IEN_CLR  = 3;
    localparam int unsigned A_MODE     = 4;
    localparam int unsigned A_WIDTH    = 5;
    localparam int unsigned A_PRESC    = 6;
    localparam int unsigned A_ONESHOT  = 7;
    localparam int unsigned A_EVT_BASE = 8;
    localparam int unsigned A_CC_BASE  = 16;

    // Task word bit positions
    localparam int unsigned T_START    = 0;
    localparam int unsigned T_STOP     = 1;
    localparam int unsigned T_COUNT    = 2;
    localparam int unsigned T_CLEAR    = 3;
    localparam int unsigned T_SHUT     = 4;
    localparam int unsigned T_CAP_BASE = 8;

    // Offset of the compare-clear bits in the shortcut word
    localparam int unsigned SHORT_CLR_OFS = 8;

    // Mode code for prescaled timer operation
    localparam logic [1:0] MODE_TIMER = 2'd0;

endpackage

// File: rtl/cc_timer_presc.sv
module cc_timer_presc #(
    parameter int unsigned PRE_W = 4,
    parameter int unsigned DIV_W = 9
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             sync_clr,
    input  logic [PRE_W-1:0] presc,
    output logic             tick
);
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] mask;

    // Low p bits all ones marks the last cycle of a 2^p period
    always_comb begin
        mask = (DIV_W'(1) << presc) - DIV_W'(1);
        tick = ((div_q & mask) == mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (sync_clr) begin
            div_q <= '0;
        end else if (run) begin
            div_q <= div_q + DIV_W'(1);
        end
    end
endmodule

// File: rtl/cc_timer_chan.sv
module cc_timer_chan #(
    parameter int unsigned DATA_W = 32
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic [DATA_W-1:0] cnt_now,
    input  logic [DATA_W-1:0] cnt_inc,
    input  logic              cap,
    input  logic              wr_cc,
    input  logic              clr_evt,
    input  logic [DATA_W-1:0] wdata,
    input  logic              one_shot,
    output logic [DATA_W-1:0] cc_q,
    output logic              evt_q,
    output logic              match
);
    logic armed_q;

    // A compare happens only on an increment that lands on the stored value
    assign match = step && (cnt_inc == cc_q) && (armed_q || !one_shot);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cc_q    <= '0;
            evt_q   <= 1'b0;
            armed_q <= 1'b1;
        end else begin
            if (cap) begin
                cc_q <= cnt_now;
            end else if (wr_cc) begin
                cc_q <= wdata;
            end

            if (match) begin
                evt_q <= 1'b1;
            end else if (clr_evt) begin
                evt_q <= 1'b0;
            end

            if (wr_cc) begin
                armed_q <= 1'b1;
            end else if (match && one_shot) begin
                armed_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/cc_timer.sv
module cc_timer
    import cc_timer_pkg::*;
#(
    parameter int unsigned NCH       = 4,
    parameter int unsigned ADDR_W    = 6,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned PRESC_MAX = 9
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    localparam int unsigned PRE_W = $clog2(PRESC_MAX + 1);
    localparam int unsigned DIV_W = PRESC_MAX;
    localparam logic [DATA_W-1:0] ONES = '1;

    run_state_e state_q, state_d;
    logic running;

    // Decoded write strobes
    logic hit_task, hit_short, hit_ien_set, hit_ien_clr;
    logic hit_mode, hit_width, hit_presc, hit_os;
    logic [NCH-1:0] hit_cc, evt_zero;

    // Task pulses
    logic t_start, t_stop, t_count, t_clear, t_shut;
    logic [NCH-1:0] t_cap;

    // Configuration
    logic [NCH-1:0]   short_stop_q, short_clr_q, ien_q, os_q;
    logic [1:0]       mode_q, width_q;
    logic [PRE_W-1:0] presc_q;

    // Counter path
    logic [DATA_W-1:0] cnt_q, cnt_inc, wmask;
    logic [4:0]        wshift;
    logic              presc_tick, tick, clr_any, step;
    logic              pend_clr_q, pend_stop_q;

    // Channels
    logic [DATA_W-1:0] cc_arr [NCH];
    logic [NCH-1:0]    evt_vec, match_vec;

    assign running = (state_q == ST_RUN);

    // Address decode
    always_comb begin
        hit_task    = bus_we && (bus_addr == ADDR_W'(A_TASK));
        hit_short   = bus_we && (bus_addr == ADDR_W'(A_SHORT));
        hit_ien_set = bus_we && (bus_addr == ADDR_W'(A_IEN_SET));
        hit_ien_clr = bus_we && (bus_addr == ADDR_W'(A_IEN_CLR));
        hit_mode    = bus_we && (bus_addr == ADDR_W'(A_MODE));
        hit_width   = bus_we && (bus_addr == ADDR_W'(A_WIDTH));
        hit_presc   = bus_we && (bus_addr == ADDR_W'(A_PRESC));
        hit_os      = bus_we && (bus_addr == ADDR_W'(A_ONESHOT));
        for (int n = 0; n < NCH; n++) begin
            hit_cc[n]   = bus_we && (bus_addr == ADDR_W'(A_CC_BASE + n));
            evt_zero[n] = bus_we && (bus_addr == ADDR_W'(A_EVT_BASE + n))
                          && (bus_wdata == '0);
        end
    end

    // Task word split; every set bit acts in this cycle
    always_comb begin
        t_start = hit_task && bus_wdata[T_START];
        t_stop  = hit_task && bus_wdata[T_STOP];
        t_count = hit_task && bus_wdata[T_COUNT];
        t_clear = hit_task && bus_wdata[T_CLEAR];
        t_shut  = hit_task && bus_wdata[T_SHUT];
        t_cap   = hit_task ? bus_wdata[T_CAP_BASE +: NCH] : '0;
    end

    // Width mask from the width code
    always_comb begin
        unique case (width_q)
            2'd0:    wshift = 5'd24;
            2'd1:    wshift = 5'd16;
            2'd2:    wshift = 5'd8;
            default: wshift = 5'd0;
        endcase
        wmask = ONES >> wshift;
    end

    cc_timer_presc #(
        .PRE_W (PRE_W),
        .DIV_W (DIV_W)
    ) u_presc (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (running),
        .sync_clr (t_clear || t_shut),
        .presc    (presc_q),
        .tick     (presc_tick)
    );

    // Tick source; a pending stop freezes the count in its final cycle
    always_comb begin
        tick    = running && !pend_stop_q &&
                  ((mode_q == MODE_TIMER) ? presc_tick : t_count);
        clr_any = t_clear || t_shut || pend_clr_q;
        step    = tick && !clr_any;
        cnt_inc = (cnt_q + DATA_W'(1)) & wmask;
    end

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        cc_timer_chan #(
            .DATA_W (DATA_W)
        ) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .step     (step),
            .cnt_now  (cnt_q),
            .cnt_inc  (cnt_inc),
            .cap      (t_cap[g]),
            .wr_cc    (hit_cc[g]),
            .clr_evt  (evt_zero[g]),
            .wdata    (bus_wdata),
            .one_shot (os_q[g]),
            .cc_q     (cc_arr[g]),
            .evt_q    (evt_vec[g]),
            .match    (match_vec[g])
        );
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: START and STOP transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (t_start && !t_stop && !t_shut && !pend_stop_q) begin
                    state_d = ST_RUN;
                end
            end
            ST_RUN: begin
                if (t_stop || t_shut || pend_stop_q) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Counter and shortcut pipeline
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q       <= '0;
            pend_clr_q  <= 1'b0;
            pend_stop_q <= 1'b0;
        end else begin
            if (clr_any) begin
                cnt_q <= '0;
            end else if (tick) begin
                cnt_q <= cnt_inc;
            end
            pend_clr_q  <= |(match_vec & short_clr_q);
            pend_stop_q <= |(match_vec & short_stop_q);
        end
    end

    // Configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            short_stop_q <= '0;
            short_clr_q  <= '0;
            ien_q        <= '0;
            os_q         <= '0;
            mode_q       <= '0;
            width_q      <= '0;
            presc_q      <= '0;
        end else begin
            if (hit_short) begin
                short_stop_q <= bus_wdata[NCH-1:0];
                short_clr_q  <= bus_wdata[SHORT_CLR_OFS +: NCH];
            end
            if (hit_ien_set) begin
                ien_q <= ien_q | bus_wdata[NCH-1:0];
            end else if (hit_ien_clr) begin
                ien_q <= ien_q & ~bus_wdata[NCH-1:0];
            end
            if (hit_os) begin
                os_q <= bus_wdata[NCH-1:0];
            end
            if (hit_mode) begin
                mode_q <= bus_wdata[1:0];
            end
            if (hit_width) begin
                width_q <= bus_wdata[1:0];
            end
            if (hit_presc) begin
                presc_q <= (bus_wdata[PRE_W-1:0] > PRE_W'(PRESC_MAX))
                           ? PRE_W'(PRESC_MAX) : bus_wdata[PRE_W-1:0];
            end
        end
    end

    // Outputs: read mux and interrupt line
    always_comb begin
        bus_rdata = '0;
        irq       = |(evt_vec & ien_q);
        unique case (bus_addr)
            ADDR_W'(A_SHORT): begin
                bus_rdata[NCH-1:0]            = short_stop_q;
                bus_rdata[SHORT_CLR_OFS +: NCH] = short_clr_q;
            end
            ADDR_W'(A_IEN_SET), ADDR_W'(A_IEN_CLR): bus_rdata[NCH-1:0] = ien_q;
            ADDR_W'(A_MODE):    bus_rdata[1:0]       = mode_q;
            ADDR_W'(A_WIDTH):   bus_rdata[1:0]       = width_q;
            ADDR_W'(A_PRESC):   bus_rdata[PRE_W-1:0] = presc_q;
            ADDR_W'(A_ONESHOT): bus_rdata[NCH-1:0]   = os_q;
            default: begin
                for (int n = 0; n < NCH; n++) begin
                    if (bus_addr == ADDR_W'(A_EVT_BASE + n)) begin
                        bus_rdata[0] = evt_vec[n];
                    end
                    if (bus_addr == ADDR_W'(A_CC_BASE + n)) begin
                        bus_rdata = cc_arr[n];
                    end
                end
            end
        endcase
    end
endmodule

// File: rtl/cc_timer_sva.sv
module cc_timer_sva #(
    parameter int unsigned NCH       = 4,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned PRE_W     = 4,
    parameter int unsigned PRESC_MAX = 9
)(
    input logic              clk,
    input logic              rst_n,
    input logic              t_stop,
    input logic              t_clear,
    input logic              t_shut,
    input logic              running,
    input logic              clr_any,
    input logic [DATA_W-1:0] cnt_q,
    input logic [NCH-1:0]    evt_vec,
    input logic [NCH-1:0]    match_vec,
    input logic [NCH-1:0]    short_clr_q,
    input logic [PRE_W-1:0]  presc_q
);
    assert_stop_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
        t_stop |=> !running);

    assert_clear_task_R2: assert property (@(posedge clk) disable iff (!rst_n)
        t_clear |=> (cnt_q == '0));

    assert_presc_sat_R3: assert property (@(posedge clk) disable iff (!rst_n)
        presc_q <= PRE_W'(PRESC_MAX));

    assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !clr_any) |=> $stable(cnt_q));

    assert_flag_needs_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|(evt_vec & ~$past(evt_vec))) |-> $past(running));

    assert_short_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|(match_vec & short_clr_q)) |-> ##2 (cnt_q == '0));

    assert_shutdown_R11: assert property (@(posedge clk) disable iff (!rst_n)
        t_shut |=> (!running && cnt_q == '0));
endmodule

bind cc_timer cc_timer_sva #(
    .NCH       (NCH),
    .DATA_W    (DATA_W),
    .PRE_W     (PRE_W),
    .PRESC_MAX (PRESC_MAX)
) u_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .t_stop      (t_stop),
    .t_clear     (t_clear),
    .t_shut      (t_shut),
    .running     (running),
    .clr_any     (clr_any),
    .cnt_q       (cnt_q),
    .evt_vec     (evt_vec),
    .match_vec   (match_vec),
    .short_clr_q (short_clr_q),
    .presc_q     (presc_q)
);

// File: tb/cc_timer_tb.sv
module cc_timer_tb;
    localparam int N = 4;
    localparam logic [31:0] K_START = 32'h1, K_STOP = 32'h2, K_COUNT = 32'h4,
                            K_CLEAR = 32'h8, K_SHUT = 32'h10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    cc_timer u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    // Behavioural reference model
    logic [31:0] m_cnt;
    logic [31:0] m_cc [N];
    logic [N-1:0] m_evt, m_ien, m_os, m_arm, m_sstop, m_sclr, m_match;
    logic [1:0]  m_mode, m_width;
    logic [3:0]  m_pre;
    logic [8:0]  m_div, m_pm;
    logic [31:0] m_wm, m_inc, m_t;
    bit m_run, m_pclr, m_pstop, m_tick, m_clr;

    function automatic logic [31:0] cap_cap(int ch);
        return 32'h1 << (8 + ch);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_evt = 0; m_ien = 0; m_os = 0; m_arm = '1;
            m_sstop = 0; m_sclr = 0; m_mode = 0; m_width = 0; m_pre = 0;
            m_div = 0; m_run = 0; m_pclr = 0; m_pstop = 0;
            for (int n = 0; n < N; n++) m_cc[n] = 0;
        end else begin
            m_t  = (bus_we && bus_addr == 0) ? bus_wdata : 32'h0;
            m_wm = (m_width == 0) ? 32'hFF : (m_width == 1) ? 32'hFFFF :
                   (m_width == 2) ? 32'hFF_FFFF : 32'hFFFF_FFFF;
            m_pm = (9'd1 << m_pre) - 9'd1;
            m_tick = m_run && !m_pstop &&
                     ((m_mode == 0) ? ((m_div & m_pm) == m_pm) : m_t[2]);
            m_clr = m_t[3] || m_t[4] || m_pclr;
            m_inc = (m_cnt + 1) & m_wm;
            for (int n = 0; n < N; n++)
                m_match[n] = m_tick && !m_clr && (m_inc == m_cc[n]) && (m_arm[n] || !m_os[n]);
            // captures use the pre-update count
            for (int n = 0; n < N; n++) begin
                if (m_t[8+n]) m_cc[n] = m_cnt;
                else if (bus_we && bus_addr == 16 + n) m_cc[n] = bus_wdata;
                if (bus_we && bus_addr == 16 + n) m_arm[n] = 1'b1;
                else if (m_match[n] && m_os[n]) m_arm[n] = 1'b0;
                if (m_match[n]) m_evt[n] = 1'b1;
                else if (bus_we && bus_addr == 8 + n && bus_wdata == 0) m_evt[n] = 1'b0;
            end
            m_div = (m_t[3] || m_t[4]) ? 9'd0 : m_run ? m_div + 9'd1 : m_div;
            m_cnt = m_clr ? 32'h0 : m_tick ? m_inc : m_cnt;
            if (m_t[1] || m_t[4] || m_pstop) m_run = 0;
            else if (m_t[0]) m_run = 1;
            m_pclr  = |(m_match & m_sclr);
            m_pstop = |(m_match & m_sstop);
            if (bus_we) begin
                case (bus_addr)
                    1: begin m_sstop = bus_wdata[N-1:0]; m_sclr = bus_wdata[8 +: N]; end
                    2: m_ien = m_ien | bus_wdata[N-1:0];
                    3: m_ien = m_ien & ~bus_wdata[N-1:0];
                    4: m_mode = bus_wdata[1:0];
                    5: m_width = bus_wdata[1:0];
                    6: m_pre = (bus_wdata[3:0] > 9) ? 4'd9 : bus_wdata[3:0];
                    7: m_os = bus_wdata[N-1:0];
                    default: ;
                endcase
            end
        end
    end

    function automatic logic [31:0] m_read(int a);
        logic [31:0] r = 0;
        case (a)
            1: begin r[N-1:0] = m_sstop; r[8 +: N] = m_sclr; end
            2, 3: r[N-1:0] = m_ien;
            4: r[1:0] = m_mode;
            5: r[1:0] = m_width;
            6: r[3:0] = m_pre;
            7: r[N-1:0] = m_os;
            default: begin
                for (int n = 0; n < N; n++) begin
                    if (a == 8 + n)  r[0] = m_evt[n];
                    if (a == 16 + n) r = m_cc[n];
                end
            end
        endcase
        return r;
    endfunction

    // irq against the model on every clock (R8)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (irq !== |(m_evt & m_ien)) begin
                fails++;
                $display("FAIL R8 irq t=%0t actual=%0b expected=%0b", $time, irq, |(m_evt & m_ien));
            end
        end
    end

    task automatic wr(input int a, input logic [31:0] d);
        bus_we = 1'b1; bus_addr = 6'(a); bus_wdata = d;
        @(posedge clk); #2;
        bus_we = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic rd(input int a, input string tag);
        logic [31:0] exp;
        bus_we = 1'b0; bus_addr = 6'(a);
        #1;
        exp = m_read(a);
        checks++;
        if (bus_rdata !== exp) begin
            fails++;
            $display("FAIL %s addr=%0d actual=%h expected=%h", tag, a, bus_rdata, exp);
        end
        @(posedge clk); #2;
    endtask

    task automatic rd_lit(input int a, input logic [31:0] exp, input string tag);
        bus_we = 1'b0; bus_addr = 6'(a);
        #1;
        checks++;
        if (bus_rdata !== exp) begin
            fails++;
            $display("FAIL %s addr=%0d actual=%h expected=%h", tag, a, bus_rdata, exp);
        end
        @(posedge clk); #2;
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        idle(1);

        // R1 reset state
        for (int a = 0; a < 8; a++) rd_lit(a, 32'h0, "R1");
        for (int n = 0; n < N; n++) begin
            rd_lit(8 + n, 32'h0, "R1");
            rd_lit(16 + n, 32'h0, "R1");
        end

        // R12 full-width register
        wr(17, 32'hDEAD_BEEF); rd_lit(17, 32'hDEAD_BEEF, "R12");
        // R3 prescaler saturates
        wr(6, 15); rd_lit(6, 32'd9, "R3"); wr(6, 0);

        // R6 / R8 compare flag and interrupt
        wr(5, 3); wr(16, 5); wr(2, 1); rd(2, "R8");
        wr(0, K_START); idle(10);
        rd(8, "R6"); wr(8, 1); rd_lit(8, 32'h1, "R6"); wr(8, 0); rd_lit(8, 32'h0, "R6");
        wr(3, 1); rd_lit(3, 32'h0, "R8");
        wr(0, K_STOP); wr(0, cap_cap(0)); rd(16, "R9");

        // R3 prescaled ticks
        wr(6, 2); wr(0, K_CLEAR | K_START); idle(13);
        wr(0, cap_cap(1)); rd(17, "R3"); idle(5); wr(0, cap_cap(2)); rd(18, "R3");
        wr(0, K_STOP);

        // R9 clear and capture together
        wr(6, 0); wr(0, K_START); idle(7);
        wr(0, K_CLEAR | cap_cap(3)); rd(19, "R9"); wr(0, cap_cap(0)); rd(16, "R9");
        wr(0, K_STOP);

        // R4 counter modes, R9 count with capture
        wr(4, 1); wr(0, K_CLEAR | K_START);
        for (int i = 0; i < 5; i++) wr(0, K_COUNT);
        wr(0, K_COUNT | cap_cap(1)); rd_lit(17, 32'd5, "R9");
        wr(0, cap_cap(1)); rd_lit(17, 32'd6, "R4");
        wr(0, K_STOP);
        for (int i = 0; i < 3; i++) wr(0, K_COUNT);
        wr(0, cap_cap(2)); rd_lit(18, 32'd6, "R4");
        wr(4, 2); wr(0, K_START); wr(0, K_COUNT); wr(0, cap_cap(2)); rd_lit(18, 32'd7, "R4");
        wr(0, K_STOP);

        // R5 8-bit wrap, compare at zero
        wr(4, 0); wr(5, 0); wr(16, 0); wr(8, 0); wr(0, K_CLEAR | K_START); idle(300);
        wr(0, cap_cap(1)); rd(17, "R5"); rd_lit(8, 32'h1, "R5");
        wr(0, K_STOP);

        // R7 compare-clear shortcut
        wr(5, 3); wr(17, 10); wr(9, 0); wr(1, 32'h1 << 9); rd(1, "R7");
        wr(0, K_CLEAR | K_START); idle(40);
        wr(0, cap_cap(3)); rd(19, "R7"); rd(9, "R7");
        wr(0, K_STOP);

        // R7 compare-stop shortcut
        wr(1, 32'h4); wr(18, 20); wr(0, K_CLEAR | K_START); idle(30);
        wr(0, cap_cap(3)); rd_lit(19, 32'd20, "R7"); idle(3);
        wr(0, cap_cap(3)); rd_lit(19, 32'd20, "R7");

        // R10 one-shot
        wr(1, 0); wr(4, 1); wr(7, 1); wr(16, 3); wr(8, 0);
        wr(0, K_CLEAR | K_START);
        for (int i = 0; i < 3; i++) wr(0, K_COUNT);
        rd_lit(8, 32'h1, "R10"); wr(8, 0); wr(0, K_CLEAR);
        for (int i = 0; i < 3; i++) wr(0, K_COUNT);
        rd_lit(8, 32'h0, "R10");
        wr(16, 3); wr(0, K_CLEAR);
        for (int i = 0; i < 3; i++) wr(0, K_COUNT);
        rd_lit(8, 32'h1, "R10");
        wr(7, 0);

        // R2 stop beats start
        wr(0, K_STOP); wr(0, K_CLEAR); wr(0, K_START | K_STOP); wr(0, K_COUNT);
        wr(0, cap_cap(1)); rd_lit(17, 32'h0, "R2"); rd_lit(0, 32'h0, "R2");

        // R11 shutdown
        wr(4, 0); wr(0, K_START); idle(9); wr(0, K_SHUT); idle(4);
        wr(0, cap_cap(2)); rd_lit(18, 32'h0, "R11");

        // R12 value above width never matches
        wr(5, 0); wr(16, 32'h105); wr(8, 0); wr(0, K_CLEAR | K_START); idle(300);
        rd_lit(8, 32'h0, "R12"); wr(0, K_STOP);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule